// File: doc/BRIEF.md
# Three-Channel Timer Input Capture with Coherent Byte Readout

This block timestamps external events against a 16-bit free-running count. Each of three channels brings its input pin into the clock domain through a two-flop synchronizer and watches the synchronized level for the edge type chosen for that channel. When a chosen edge appears, the whole count is stored into that channel's 16-bit capture register in one parallel load, and the channel's sticky flag is set. The count is supplied from outside as `cnt_in`, and the block samples the value present in the cycle where the synchronized edge is seen.

Software reaches the block over a byte-wide bus with a combinational read path. A capture register is read as two bytes, high byte first. Reading the high byte holds off any load into that channel at the end of that same bus cycle, so the low byte read in the next cycle belongs to the same value. A capture that is held off in this way is kept pending and loads one cycle later. It is not discarded.

Top module: `tcap_unit`

## Requirements
- R1: A level change on `cap_pin[c]` driven during cycle k, when it matches the channel's edge mode, loads the count present during cycle k+2 into capture register c. The new value can be read from cycle k+3 on.
- R2: The edge mode of channel c is held in bits [2c+1:2c] of the control byte at address 6, with 00 = off, 01 = rising, 10 = falling and 11 = both. The control byte reads back as written. An edge that the mode does not select causes no capture.
- R3: A channel whose mode is 00 never loads its capture register and never sets its flag.
- R4: Address 2c returns bits [15:8] of capture register c and address 2c+1 returns bits [7:0]. Writes to these addresses change nothing.
- R5: A high-byte read of channel c in one cycle blocks any load into capture register c at the end of that cycle. A low-byte read in the next cycle therefore returns the low half of the same value.
- R6: A capture that is blocked by R5 is not lost. It loads at the end of the first cycle without a high-byte read of that channel, and it keeps the count from its own event cycle.
- R7: Every load into capture register c sets bit c of the flag byte at address 7.
- R8: Writing 1 to flag bit c clears it and writing 0 leaves it unchanged. A load in the same cycle as the clear wins, so the flag stays set.
- R9: After reset the control byte and the flag byte read as zero. Capture registers are not initialised.
- R10: A channel holds one pending capture at most. A second selected edge that is also blocked replaces the pending count with the newer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 16 | Free-running count to be captured |
| cap_pin | input | 3 | Asynchronous event inputs, one per channel |
| bus_addr | input | 3 | Byte register address |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |

## Verification
The hardest case to reach is an edge whose synchronized arrival falls exactly on a high-byte read, and worse, a second edge that arrives while the first one is still held off. The bench reaches both by driving the pin and the bus from a single cycle-counted timeline. It toggles the pin, waits exactly two cycles, and then issues one or two back-to-back high-byte reads. The pending count is then visible only through the value that finally loads. Random mode and pin patterns add coverage of edge selection and flag behaviour around these directed sequences.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // True when the transition prev->cur is one the mode asks for.
  function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = !prev && cur;
    fall = prev && !cur;
    case (mode)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_ANY:  return rise || fall;
      default:   return 1'b0;
    endcase
  endfunction

  // Address of the high byte of a channel; the low byte follows it.
  function automatic int unsigned hi_addr(int unsigned ch);
    return 2 * ch;
  endfunction

endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);
  import tcap_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hit = edge_match(edge_mode_e'(mode), prev_q, sync_q[SYNC_STAGES-1]);

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             blocked,
  input  logic [CNT_W-1:0] cnt,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_q,
  output logic             load,
  output logic             flag_q
);
  logic             pend_v;
  logic [CNT_W-1:0] pend_val;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load     = !blocked && (hit || pend_v);
    load_val = hit ? cnt : pend_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (blocked) begin
        if (hit) pend_v <= 1'b1;
      end else begin
        pend_v <= 1'b0;
      end
      if (load)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // Capture data is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (blocked && hit) pend_val <= cnt;
    if (load)           cap_q    <= load_val;
  end

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit #(
  parameter int NUM_CH      = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [NUM_CH-1:0] cap_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  import tcap_pkg::*;

  localparam int CTRL_ADDR = 2 * NUM_CH;
  localparam int FLAG_ADDR = 2 * NUM_CH + 1;

  logic [7:0]             ctrl_q;
  logic [NUM_CH-1:0]      cap_hit;
  logic [NUM_CH-1:0]      cap_blocked;
  logic [NUM_CH-1:0]      cap_load;
  logic [NUM_CH-1:0]      flag_q;
  logic                   flag_wr;
  logic [CNT_W-1:0]       cap_val [NUM_CH];

  assign flag_wr = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          ctrl_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR))   ctrl_q <= bus_wdata;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cap_blocked[c] = bus_rd && (bus_addr == ADDR_W'(hi_addr(c)));

    tcap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_pin[c]),
      .mode (ctrl_q[2*c +: 2]),
      .hit  (cap_hit[c])
    );

    tcap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (cap_hit[c]),
      .blocked (cap_blocked[c]),
      .cnt     (cnt_in),
      .flag_clr(flag_wr && bus_wdata[c]),
      .cap_q   (cap_val[c]),
      .load    (cap_load[c]),
      .flag_q  (flag_q[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(FLAG_ADDR)) bus_rdata = {{(8-NUM_CH){1'b0}}, flag_q};
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(hi_addr(c)))     bus_rdata = cap_val[c][CNT_W-1 -: 8];
      if (bus_addr == ADDR_W'(hi_addr(c) + 1)) bus_rdata = cap_val[c][7:0];
    end
  end

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        mode,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] blocked,
  input logic [NUM_CH-1:0] load,
  input logic [NUM_CH-1:0] flags,
  input logic              flag_wr,
  input logic [7:0]        wdata
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_off_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*c +: 2] == 2'b00) |-> !hit[c]);

    assert_blocked_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[c] |-> !load[c]);

    assert_deferred_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked[c] && hit[c]) |=> (load[c] || blocked[c]));

    assert_load_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load[c] |=> flags[c]);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wdata[c] && !load[c]) |=> !flags[c]);
  end
endmodule

bind tcap_unit tcap_checker #(.NUM_CH(NUM_CH)) u_tcap_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (ctrl_q),
  .hit    (cap_hit),
  .blocked(cap_blocked),
  .load   (cap_load),
  .flags  (flag_q),
  .flag_wr(flag_wr),
  .wdata  (bus_wdata)
);

// File: tb/test_tcap_unit.sv
module test_tcap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_in = 16'h1000;
  logic [2:0]  pins = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  wire  [7:0]  rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tcap_unit i_tcap_unit (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cap_pin(pins),
    .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  always #2 clk = ~clk;

  // Bench model of edge selection (R2).
  function automatic bit want_edge(logic [1:0] m, logic old_l, logic new_l);
    if (old_l == new_l) return 0;
    if (m == 2'b11) return 1;
    if (m == 2'b01) return new_l;
    if (m == 2'b10) return !new_l;
    return 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    cnt_in = cnt_in + 16'd1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_cap(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd_byte(3'(2*ch), h);
    rd_byte(3'(2*ch+1), l);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b, h0, l0;
    logic [15:0] v, old_v, c0;
    logic [1:0]  mode_m [3];
    logic        lvl_m  [3];
    logic [15:0] cap_m  [3];
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) begin mode_m[i] = 2'b00; lvl_m[i] = 1'b0; cap_m[i] = '0; end

    idle(3);
    #1 rst_n = 1'b1;
    tick();

    // R9: reset values
    rd_byte(3'd6, b); chk("R9 ctrl", b, 8'h00);
    rd_byte(3'd7, b); chk("R9 flags", b, 8'h00);

    // R2: ch0 rising, ch1 falling, ch2 both
    wr_byte(3'd6, 8'h39);
    rd_byte(3'd6, b); chk("R2 ctrl readback", b, 8'h39);

    // R1: rising edge on ch0
    c0 = cnt_in; pins[0] = 1'b1;
    idle(3);
    rd_cap(0, v); chk("R1 capture ch0", v, c0 + 16'd2);
    rd_byte(3'd7, b); chk("R7 flag ch0", b, 8'h01);
    wr_byte(3'd7, 8'h00);
    rd_byte(3'd7, b); chk("R8 write 0 keeps flag", b, 8'h01);
    wr_byte(3'd7, 8'h01);
    rd_byte(3'd7, b); chk("R8 write 1 clears", b, 8'h00);

    // R2: rising edge on falling-mode ch1 ignored, then falling captured
    pins[1] = 1'b1; idle(4);
    rd_byte(3'd7, b); chk("R2 unselected edge", b, 8'h00);
    c0 = cnt_in; pins[1] = 1'b0;
    idle(3);
    rd_cap(1, v); chk("R2 falling capture ch1", v, c0 + 16'd2);
    wr_byte(3'd7, 8'h07);

    // R3: ch0 off
    wr_byte(3'd6, 8'h38);
    rd_cap(0, old_v);
    pins[0] = 1'b0; idle(4);
    pins[0] = 1'b1; idle(4);
    rd_byte(3'd7, b); chk("R3 no flag when off", b, 8'h00);
    rd_cap(0, v); chk("R3 register unchanged", v, old_v);

    // R4: write to capture bytes ignored
    wr_byte(3'd0, ~old_v[15:8]);
    wr_byte(3'd1, ~old_v[7:0]);
    rd_cap(0, v); chk("R4 read-only capture", v, old_v);

    // R5/R6: edge lands on a high-byte read of ch2
    rd_cap(2, old_v);
    c0 = cnt_in; pins[2] = 1'b1;
    idle(2);
    rd_byte(3'd4, h0);
    rd_byte(3'd5, l0);
    chk("R5 coherent pair", {h0, l0}, old_v);
    rd_cap(2, v); chk("R6 deferred value", v, c0 + 16'd2);
    rd_byte(3'd7, b); chk("R6/R7 deferred flag", b, 8'h04);
    wr_byte(3'd7, 8'h04);

    // R10: two blocked edges, newer pending wins
    rd_cap(2, old_v);
    c0 = cnt_in; pins[2] = 1'b0;
    tick();
    pins[2] = 1'b1;
    tick();
    rd_byte(3'd4, h0);
    rd_byte(3'd4, b);
    rd_byte(3'd5, l0);
    chk("R10 hold during double block", {h0, l0}, old_v);
    rd_cap(2, v); chk("R10 newer pending kept", v, c0 + 16'd3);
    wr_byte(3'd7, 8'h07);

    // R8: load wins over same-cycle clear (ch0 rising)
    wr_byte(3'd6, 8'h39);
    pins[0] = 1'b0; idle(4);
    wr_byte(3'd7, 8'h07);
    pins[0] = 1'b1;
    idle(2);
    wr_byte(3'd7, 8'h01);
    rd_byte(3'd7, b); chk("R8 set beats clear", b, 8'h01);
    wr_byte(3'd7, 8'h07);

    // Random mode and pin patterns (R1, R2, R3, R7)
    for (int i = 0; i < 3; i++) lvl_m[i] = pins[i];
    for (int it = 0; it < 60; it++) begin
      int ch;
      bit tog, hit;
      for (int i = 0; i < 3; i++) mode_m[i] = 2'($urandom_range(0, 3));
      wr_byte(3'd6, {2'b00, mode_m[2], mode_m[1], mode_m[0]});
      ch  = $urandom_range(0, 2);
      tog = $urandom_range(0, 3) != 0;
      rd_cap(ch, old_v);
      hit = tog && want_edge(mode_m[ch], lvl_m[ch], !lvl_m[ch]);
      c0 = cnt_in;
      if (tog) begin pins[ch] = !lvl_m[ch]; lvl_m[ch] = !lvl_m[ch]; end
      idle(3);
      rd_cap(ch, v);
      chk(hit ? "R1 random capture" : "R3 random no capture", v, hit ? c0 + 16'd2 : old_v);
      rd_byte(3'd7, b);
      chk("R7 random flag", b, hit ? 8'(1 << ch) : 8'h00);
      wr_byte(3'd7, 8'h07);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule